// File: doc/BRIEF.md
# Mesh-Walk Sequencer with Vertex Write-Out

This block drives a microcode evaluation core across a two-dimensional grid of points. When started, it visits every grid point row by row. Before each run it gives the core the point's column and row indices, clears its program counter and lets it execute. The run ends when the core reports a vector-output event carrying two 32-bit words. The sequencer then stores that pair in memory at a slot computed from the point's position. It uses a request/acknowledge write port and sends one word per transfer.

Each run is guarded by an instruction budget. A point whose program retires the budgeted number of ordinary instructions without producing a vector output is abandoned, and a sticky error flag is raised. When the last point has been handled, the sequencer publishes the number of grid points, drops busy and pulses a one-cycle completion interrupt.

Top module: `mesh_walk_seq`

## Requirements
- R1: The grid extent and the base address are sampled when a walk is accepted. Row index y runs from 0 to the sampled vertical last value inclusive as the outer loop, and column index x runs from 0 to the horizontal last value inclusive as the inner loop. Before each run, one cycle has `coord_load_o` and `pc_clr_o` high with `coord_x_o`/`coord_y_o` showing that point.
- R2: `core_run_o` rises in the cycle after the coordinate load. It stays high until the core reports `core_vout_i` or the instruction budget expires, and it is never high together with `wr_req_o`.
- R3: The slot address of a point is base + 8 × (128 × y + x), using 32-bit wrap-around arithmetic.
- R4: Each vector output produces exactly two writes: the first word at the slot address, then the second word at slot address + 4. Both words are byte-reversed on `wr_data_o`, so bits [7:0] carry word bits [31:24] and bits [31:24] carry word bits [7:0].
- R5: While `wr_req_o` is high and `wr_ack_i` is low, the request, the address and the data hold their values. Both writes of a point are acknowledged before the next point's coordinate load.
- R6: After the second write of a point is acknowledged, `last_dma_o` holds that write's address (slot + 4). A point that is abandoned leaves it unchanged.
- R7: If a run sees MAX_INSN `core_step_i` pulses without `core_vout_i`, that point is abandoned. `core_run_o` drops, no write is issued for the point, `err_o` is set, and the walk continues with the next point. `err_o` clears only when a new walk is accepted.
- R8: `start_i` in an idle cycle starts a walk, and `busy_o` is high from the next cycle until completion. `start_i` and any change of the extent or base inputs during a walk have no effect on that walk.
- R9: On completion, in one and the same cycle, `irq_o` is high for exactly that cycle, `busy_o` is low, and `vertex_cnt_o` equals (horizontal last + 1) × (vertical last + 1).
- R10: After reset, `busy_o`, `irq_o`, `err_o`, `wr_req_o` and `core_run_o` are low, and `last_dma_o` and `vertex_cnt_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| h_last_i | input | COORD_W | Last column index |
| v_last_i | input | COORD_W | Last row index |
| mesh_base_i | input | AW | Base byte address of the output area |
| coord_load_o | output | 1 | Load coordinates into the core's coordinate registers |
| pc_clr_o | output | 1 | Clear the core's program counter |
| coord_x_o | output | COORD_W | Column index of the current point |
| coord_y_o | output | COORD_W | Row index of the current point |
| core_run_o | output | 1 | Core is allowed to execute |
| core_step_i | input | 1 | Core retired one instruction that is not a vector output |
| core_vout_i | input | 1 | Core executed its vector-output instruction |
| core_word0_i | input | DW | First output word, valid with core_vout_i |
| core_word1_i | input | DW | Second output word, valid with core_vout_i |
| wr_req_o | output | 1 | Memory write request |
| wr_addr_o | output | AW | Write byte address |
| wr_data_o | output | DW | Write data, byte-reversed |
| wr_ack_i | input | 1 | Write accepted |
| busy_o | output | 1 | Walk in progress |
| last_dma_o | output | AW | Address of the most recent second-word write |
| vertex_cnt_o | output | 2*COORD_W+1 | Points in the last completed walk |
| err_o | output | 1 | A point in this walk exceeded its instruction budget |
| irq_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with COORD_W = 3 and MAX_INSN = 6. This lets it sweep all sixteen combinations of last column and last row from 0 to 3, and each grid stays small enough that every point's two writes can be checked one by one. The low budget brings the watchdog within a few cycles. A point abandoned after six steps and a point finishing after exactly five steps show both sides of that limit within one walk. The acknowledge latency is varied from zero to two cycles, so that the write port's hold behaviour is exercised.

// File: rtl/mesh_walk_pkg.sv
package mesh_walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RUN,
    ST_DMA,
    ST_ADV
  } walk_st_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_W0,
    PH_W1
  } dma_ph_e;
endpackage

// File: rtl/mw_addr_gen.sv
module mw_addr_gen #(
  parameter int COORD_W    = 7,
  parameter int AW         = 32,
  parameter int PITCH_LOG2 = 7,
  parameter int VTX_LOG2   = 3
) (
  input  logic [AW-1:0]      base_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  output logic [AW-1:0]      addr_o
);
  logic [AW-1:0] idx;

  always_comb begin
    idx    = (AW'(y_i) << PITCH_LOG2) + AW'(x_i);
    addr_o = base_i + (idx << VTX_LOG2);
  end
endmodule

// File: rtl/mw_insn_wdog.sv
module mw_insn_wdog #(
  parameter int MAX_INSN = 2048
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  output logic expire_o
);
  localparam int WD_W = $clog2(MAX_INSN + 1);

  logic [WD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end

  // budget is spent on the step that brings the count to MAX_INSN
  assign expire_o = step_i && (cnt_q == WD_W'(MAX_INSN - 1));
endmodule

// File: rtl/mw_dma_pair.sv
module mw_dma_pair
  import mesh_walk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] word0_i,
  input  logic [DW-1:0] word1_i,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  input  logic          wr_ack_i,
  output logic          done_o,
  output logic [AW-1:0] last_addr_o
);
  localparam int NB = DW / 8;
  localparam logic [AW-1:0] STEP = AW'(NB);

  dma_ph_e       ph_q;
  logic [AW-1:0] addr_q, last_q;
  logic [DW-1:0] w0_q, w1_q, sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      addr_q <= '0;
      w0_q   <= '0;
      w1_q   <= '0;
      last_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (go_i) begin
          ph_q   <= PH_W0;
          addr_q <= addr_i;
          w0_q   <= word0_i;
          w1_q   <= word1_i;
        end
        PH_W0: if (wr_ack_i) ph_q <= PH_W1;
        PH_W1: if (wr_ack_i) begin
          ph_q   <= PH_IDLE;
          last_q <= addr_q + STEP;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign sel       = (ph_q == PH_W1) ? w1_q : w0_q;
  assign wr_req_o  = (ph_q == PH_W0) || (ph_q == PH_W1);
  assign wr_addr_o = (ph_q == PH_W1) ? addr_q + STEP : addr_q;
  assign done_o    = (ph_q == PH_W1) && wr_ack_i;
  assign last_addr_o = last_q;

  for (genvar i = 0; i < NB; i++) begin : g_swap
    assign wr_data_o[8*i +: 8] = sel[8*(NB-1-i) +: 8];
  end
endmodule

// File: rtl/mesh_walk_seq.sv
module mesh_walk_seq
  import mesh_walk_pkg::*;
#(
  parameter int COORD_W    = 7,
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int PITCH_LOG2 = 7,
  parameter int VTX_LOG2   = 3,
  parameter int MAX_INSN   = 2048,
  localparam int VCNT_W    = 2 * COORD_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [COORD_W-1:0] h_last_i,
  input  logic [COORD_W-1:0] v_last_i,
  input  logic [AW-1:0]      mesh_base_i,
  output logic               coord_load_o,
  output logic               pc_clr_o,
  output logic [COORD_W-1:0] coord_x_o,
  output logic [COORD_W-1:0] coord_y_o,
  output logic               core_run_o,
  input  logic               core_step_i,
  input  logic               core_vout_i,
  input  logic [DW-1:0]      core_word0_i,
  input  logic [DW-1:0]      core_word1_i,
  output logic               wr_req_o,
  output logic [AW-1:0]      wr_addr_o,
  output logic [DW-1:0]      wr_data_o,
  input  logic               wr_ack_i,
  output logic               busy_o,
  output logic [AW-1:0]      last_dma_o,
  output logic [VCNT_W-1:0]  vertex_cnt_o,
  output logic               err_o,
  output logic               irq_o
);
  walk_st_e           st_q;
  logic [COORD_W-1:0] x_q, y_q, hl_q, vl_q;
  logic [AW-1:0]      base_q, pt_addr;
  logic [VCNT_W-1:0]  vcnt_q;
  logic               err_q, irq_q;
  logic               wd_expire, dma_go, dma_done;

  mw_addr_gen #(
    .COORD_W(COORD_W), .AW(AW), .PITCH_LOG2(PITCH_LOG2), .VTX_LOG2(VTX_LOG2)
  ) u_addr (
    .base_i(base_q), .x_i(x_q), .y_i(y_q), .addr_o(pt_addr)
  );

  mw_insn_wdog #(.MAX_INSN(MAX_INSN)) u_wdog (
    .clk_i, .rst_ni,
    .clr_i   (st_q == ST_SETUP),
    .step_i  ((st_q == ST_RUN) && core_step_i),
    .expire_o(wd_expire)
  );

  assign dma_go = (st_q == ST_RUN) && core_vout_i;

  mw_dma_pair #(.AW(AW), .DW(DW)) u_dma (
    .clk_i, .rst_ni,
    .go_i       (dma_go),
    .addr_i     (pt_addr),
    .word0_i    (core_word0_i),
    .word1_i    (core_word1_i),
    .wr_req_o,
    .wr_addr_o,
    .wr_data_o,
    .wr_ack_i,
    .done_o     (dma_done),
    .last_addr_o(last_dma_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      x_q    <= '0;
      y_q    <= '0;
      hl_q   <= '0;
      vl_q   <= '0;
      base_q <= '0;
      vcnt_q <= '0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          hl_q   <= h_last_i;
          vl_q   <= v_last_i;
          base_q <= mesh_base_i;
          x_q    <= '0;
          y_q    <= '0;
          err_q  <= 1'b0;
          st_q   <= ST_SETUP;
        end
        ST_SETUP: st_q <= ST_RUN;
        ST_RUN: begin
          if (core_vout_i) st_q <= ST_DMA;
          else if (wd_expire) begin
            err_q <= 1'b1;
            st_q  <= ST_ADV;
          end
        end
        ST_DMA: if (dma_done) st_q <= ST_ADV;
        ST_ADV: begin
          if (x_q == hl_q) begin
            x_q <= '0;
            if (y_q == vl_q) begin
              st_q   <= ST_IDLE;
              irq_q  <= 1'b1;
              vcnt_q <= (VCNT_W'(hl_q) + 1'b1) * (VCNT_W'(vl_q) + 1'b1);
            end else begin
              y_q  <= y_q + 1'b1;
              st_q <= ST_SETUP;
            end
          end else begin
            x_q  <= x_q + 1'b1;
            st_q <= ST_SETUP;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign coord_load_o = (st_q == ST_SETUP);
  assign pc_clr_o     = (st_q == ST_SETUP);
  assign coord_x_o    = x_q;
  assign coord_y_o    = y_q;
  assign core_run_o   = (st_q == ST_RUN);
  assign busy_o       = (st_q != ST_IDLE);
  assign vertex_cnt_o = vcnt_q;
  assign err_o        = err_q;
  assign irq_o        = irq_q;
endmodule

// File: rtl/mesh_walk_chk.sv
module mesh_walk_chk #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int MAX_INSN = 2048
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          irq_o,
  input logic          core_run_o,
  input logic          core_step_i,
  input logic          coord_load_o,
  input logic          wr_req_o,
  input logic          wr_ack_i,
  input logic [AW-1:0] wr_addr_o,
  input logic [DW-1:0] wr_data_o
);
  localparam int CW = $clog2(MAX_INSN + 2);

  logic [CW-1:0] steps_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         steps_q <= '0;
    else if (coord_load_o)               steps_q <= '0;
    else if (core_run_o && core_step_i)  steps_q <= steps_q + 1'b1;
  end

  assert_wr_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));

  assert_run_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(core_run_o && wr_req_o));

  assert_run_after_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coord_load_o |=> core_run_o);

  assert_budget_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_run_o |-> steps_q < CW'(MAX_INSN));

  assert_start_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_irq_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy_o);

  assert_irq_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
endmodule

bind mesh_walk_seq mesh_walk_chk #(.AW(AW), .DW(DW), .MAX_INSN(MAX_INSN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .irq_o       (irq_o),
  .core_run_o  (core_run_o),
  .core_step_i (core_step_i),
  .coord_load_o(coord_load_o),
  .wr_req_o    (wr_req_o),
  .wr_ack_i    (wr_ack_i),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o)
);

// File: tb/tb_mesh_walk_seq.sv
module tb_mesh_walk_seq;
  localparam int CW   = 3;
  localparam int AW   = 32;
  localparam int DW   = 32;
  localparam int MAXI = 6;
  localparam int VW   = 2 * CW + 1;

  logic          clk_i = 0;
  logic          rst_ni = 0;
  logic          start_i = 0;
  logic [CW-1:0] h_last_i = '0, v_last_i = '0;
  logic [AW-1:0] mesh_base_i = '0;
  logic          coord_load_o, pc_clr_o, core_run_o;
  logic [CW-1:0] coord_x_o, coord_y_o;
  logic          core_step_i = 0, core_vout_i = 0;
  logic [DW-1:0] core_word0_i = '0, core_word1_i = '0;
  logic          wr_req_o, wr_ack_i = 0;
  logic [AW-1:0] wr_addr_o, last_dma_o;
  logic [DW-1:0] wr_data_o;
  logic          busy_o, err_o, irq_o;
  logic [VW-1:0] vertex_cnt_o;

  always #5 clk_i = ~clk_i;

  mesh_walk_seq #(.COORD_W(CW), .AW(AW), .DW(DW), .MAX_INSN(MAXI)) dut (.*);

  int total = 0, bad = 0;
  int h, v, walk_id, ex, ey, npts, nwr, cx, cy, vx, vy, n;
  bit abort_mode, ph, last_pend;
  logic [AW-1:0] base, last_exp;
  logic [DW-1:0] w0, w1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int want(input int x, input int y);
    if (abort_mode && x == 1 && y == 0) return 1000;
    if (abort_mode && x == 0 && y == 1) return MAXI - 1;
    return (x + 2 * y) % 3;
  endfunction

  function automatic logic [DW-1:0] bswap(input logic [DW-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [AW-1:0] slot(input int x, input int y);
    return base + AW'(8 * (128 * y + x));
  endfunction

  // core model
  initial begin
    forever begin
      @(negedge clk_i);
      core_step_i = 0;
      core_vout_i = 0;
      if (coord_load_o) begin
        chk(coord_x_o == CW'(ex) && coord_y_o == CW'(ey), "R1 order", {coord_y_o, coord_x_o}, {CW'(ey), CW'(ex)});
        chk(pc_clr_o, "R1 pc_clr", pc_clr_o, 1);
        chk(!ph && !wr_req_o, "R5 pair done before load", ph, 0);
        cx = coord_x_o; cy = coord_y_o; n = 0; npts++;
        if (ex == h) begin ex = 0; ey++; end else ex++;
      end else if (core_run_o) begin
        if (n >= MAXI) chk(0, "R7 run past budget", n, MAXI - 1);
        if (n < want(cx, cy)) begin
          core_step_i = 1; n++;
        end else begin
          w0 = 32'hA1B2C300 ^ DW'(cx * 16 + cy + walk_id * 256);
          w1 = ~w0 ^ 32'h00F0_0000;
          core_word0_i = w0; core_word1_i = w1;
          core_vout_i = 1; vx = cx; vy = cy;
        end
      end
    end
  end

  // memory model
  initial begin
    int dly;
    dly = 0;
    forever begin
      @(negedge clk_i);
      wr_ack_i = 0;
      if (last_pend) begin
        chk(last_dma_o == last_exp, "R6 last_dma", last_dma_o, last_exp);
        last_pend = 0;
      end
      if (wr_req_o) begin
        if (dly > 0) dly--;
        else begin
          chk(wr_addr_o == slot(vx, vy) + (ph ? 4 : 0), "R3 address", wr_addr_o, slot(vx, vy) + (ph ? 4 : 0));
          chk(wr_data_o == bswap(ph ? w1 : w0), "R4 data", wr_data_o, bswap(ph ? w1 : w0));
          if (ph) begin last_exp = slot(vx, vy) + 4; last_pend = 1; end
          wr_ack_i = 1; ph = ~ph; nwr++;
          dly = nwr % 3;
        end
      end
    end
  end

  task automatic run_walk(input int hh, input int vv, input bit ab, input bit mid);
    int cyc;
    h = hh; v = vv; abort_mode = ab; walk_id++;
    base = 32'hFFF0_0000 + AW'(walk_id * 32'h1000);
    ex = 0; ey = 0; npts = 0; nwr = 0;
    @(negedge clk_i);
    h_last_i = CW'(hh); v_last_i = CW'(vv); mesh_base_i = base; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    chk(busy_o, "R8 busy after start", busy_o, 1);
    if (mid) begin
      repeat (5) @(negedge clk_i);
      h_last_i = 0; v_last_i = 0; mesh_base_i = 0; start_i = 1;
      @(negedge clk_i);
      start_i = 0;
      chk(busy_o, "R8 start ignored", busy_o, 1);
    end
    cyc = 0;
    while (!irq_o && cyc < 5000) begin @(negedge clk_i); cyc++; end
    if (!irq_o) begin
      chk(0, "R9 completion timeout", cyc, 0);
      return;
    end
    chk(!busy_o, "R9 busy low with irq", busy_o, 0);
    chk(vertex_cnt_o == VW'((hh + 1) * (vv + 1)), "R9 vertex count", vertex_cnt_o, (hh + 1) * (vv + 1));
    chk(npts == (hh + 1) * (vv + 1), "R1 point count", npts, (hh + 1) * (vv + 1));
    chk(nwr == 2 * ((hh + 1) * (vv + 1) - (ab ? 1 : 0)), "R7 write count", nwr, 2 * ((hh + 1) * (vv + 1) - (ab ? 1 : 0)));
    chk(err_o == ab, "R7 err flag", err_o, ab);
    chk(last_dma_o == slot(hh, vv) + 4, "R6 final last_dma", last_dma_o, slot(hh, vv) + 4);
    @(negedge clk_i);
    chk(!irq_o, "R9 irq one cycle", irq_o, 0);
    chk(!core_run_o && !wr_req_o, "R2 quiet after walk", {core_run_o, wr_req_o}, 0);
  endtask

  initial begin
    ph = 0; last_pend = 0; walk_id = 0; abort_mode = 0; h = 0; v = 0;
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !irq_o && !err_o && !wr_req_o && !core_run_o, "R10 reset flags",
        {busy_o, irq_o, err_o, wr_req_o, core_run_o}, 0);
    chk(last_dma_o == 0 && vertex_cnt_o == 0, "R10 reset values", {last_dma_o, VW'(vertex_cnt_o)}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    chk(!busy_o, "R8 idle without start", busy_o, 0);
    for (int hh = 0; hh < 4; hh++)
      for (int vv = 0; vv < 4; vv++)
        run_walk(hh, vv, (hh >= 1 && vv >= 1 && ((hh + vv) % 2 == 0)), (hh == 3 && vv == 2));
    run_walk(1, 1, 0, 0);
    chk(!err_o, "R7 err cleared by new walk", err_o, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule